// File: doc/BRIEF.md
# Compare-and-branch decision unit

This block decides, for one jump instruction of an eBPF-style program, whether the jump is taken and which instruction slot executes next. It has no condition flags: every conditional opcode fuses a comparison of the destination register against a comparand with a relative jump, so the decision is made from the opcode and the operand values alone. Both unsigned and two's-complement signed orderings are supported, together with equality, inequality and a bit-test condition. The comparand is either the source register or the 32-bit immediate, sign-extended to 64 bits.

The instruction fetch stage presents the opcode, the two register values, the immediate, the 16-bit signed offset and the current program counter with `in_valid`. One clock later the unit returns the taken flag, the next program counter in instruction slots, and an illegal flag for any opcode that is not a jump this unit handles. Call and return opcodes, instruction memory and the register file are outside the block.

Top module: `br_decide`

## Requirements
- R1: During and directly after a synchronous active-low reset, `out_valid`, `taken`, `illegal` and `next_pc` are all zero.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock; the results for an instruction appear in that same cycle.
- R3: Opcode 0x05 is an unconditional jump and is always taken.
- R4: Opcodes with upper nibble 0x1 jump when destination equals comparand; upper nibble 0x5 jumps when they differ.
- R5: Upper nibbles 0x2 (greater), 0x3 (greater or equal), 0xA (less), 0xB (less or equal) compare the 64-bit operands as unsigned values.
- R6: Upper nibbles 0x6 (greater), 0x7 (greater or equal), 0xC (less), 0xD (less or equal) compare the 64-bit operands as two's-complement signed values.
- R7: Upper nibble 0x4 jumps when the bitwise AND of destination and comparand is nonzero.
- R8: For a conditional jump, opcode bit 3 set selects the source register as comparand; bit 3 clear selects the 32-bit immediate sign-extended to 64 bits.
- R9: When taken, `next_pc` = `pc` + 1 + sign-extended `offset`, modulo 2^PC_W.
- R10: When not taken, `next_pc` = `pc` + 1, modulo 2^PC_W.
- R11: An opcode is legal only if its low three bits are 101 and it is 0x05 or has upper nibble 1-7 or A-D; any other opcode (including 0x0D, 0x85, 0x8D, 0x95) gives `illegal` = 1, `taken` = 0 and `next_pc` = `pc` + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Jump opcode |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| offset | input | 16 | Signed jump distance in slots |
| pc | input | PC_W | Current program counter in slots |
| out_valid | output | 1 | Results are valid |
| taken | output | 1 | Jump is taken |
| illegal | output | 1 | Opcode is not a handled jump |
| next_pc | output | PC_W | Next program counter in slots |

## Verification
The comparand selection and the ordering choice act in the same decision: a negative immediate is sign-extended and then judged under either unsigned or signed ordering, so one operand pattern flips the result between the two families. The sweep drives every one of the 256 opcodes against patterns built to sit on those edges (sign bit set on one side only, immediate with bit 31 set, equal after extension) and judges each taken flag against a bench-side evaluation of the requirement. The target adder shares the cycle with the decision, so the same vectors carry program counters and offsets that wrap around the counter range in both directions, and the expected slot is computed arithmetically from the expected decision.

// File: rtl/br_pkg.sv
// Shared types for the compare-and-branch decision unit.
// Assumes opcode layout: low 3 bits 101 mark the jump class, bit 3 picks the
// comparand, the upper nibble picks the condition.
package br_pkg;

    localparam int OPC_W = 8;
    localparam int VAL_W = 64;
    localparam int IMM_W = 32;
    localparam int OFF_W = 16;

    typedef enum logic [3:0] {
        COND_ALWAYS = 4'd0,
        COND_EQ     = 4'd1,
        COND_UGT    = 4'd2,
        COND_UGE    = 4'd3,
        COND_BITS   = 4'd4,
        COND_NE     = 4'd5,
        COND_SGT    = 4'd6,
        COND_SGE    = 4'd7,
        COND_ULT    = 4'd8,
        COND_ULE    = 4'd9,
        COND_SLT    = 4'd10,
        COND_SLE    = 4'd11,
        COND_NEVER  = 4'd12
    } cond_e;

    typedef struct packed {
        cond_e cond;
        logic  use_reg;
        logic  legal;
    } dec_t;

endpackage

// File: rtl/br_decode.sv
// Opcode decoder: maps a jump opcode to a condition, the comparand choice and
// a legality flag. Assumes nothing about the operands; purely combinational.
module br_decode
    import br_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);

    logic [3:0] nib;
    logic       is_jmp_class;

    assign nib          = opcode[7:4];
    assign is_jmp_class = (opcode[2:0] == 3'b101);

    // Condition lookup from the upper nibble, legality from class and nibble.
    always_comb begin
        dec.use_reg = opcode[3];
        dec.legal   = is_jmp_class;
        dec.cond    = COND_NEVER;
        unique case (nib)
            4'h0:    begin
                dec.cond  = COND_ALWAYS;
                dec.legal = is_jmp_class && !opcode[3];
            end
            4'h1:    dec.cond = COND_EQ;
            4'h2:    dec.cond = COND_UGT;
            4'h3:    dec.cond = COND_UGE;
            4'h4:    dec.cond = COND_BITS;
            4'h5:    dec.cond = COND_NE;
            4'h6:    dec.cond = COND_SGT;
            4'h7:    dec.cond = COND_SGE;
            4'hA:    dec.cond = COND_ULT;
            4'hB:    dec.cond = COND_ULE;
            4'hC:    dec.cond = COND_SLT;
            4'hD:    dec.cond = COND_SLE;
            default: dec.legal = 1'b0;
        endcase
        if (!dec.legal) dec.cond = COND_NEVER;
    end

endmodule

// File: rtl/br_compare.sv
// Comparator: evaluates one condition between the destination value and the
// comparand. Builds equality, unsigned-less and signed-less once and derives
// every ordering from them. Combinational.
module br_compare
    import br_pkg::*;
#(
    parameter int W = VAL_W
) (
    input  cond_e          cond,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           hit
);

    logic eq, ult, slt, any_bit;

    assign eq      = (a == b);
    assign ult     = (a < b);
    assign slt     = ($signed(a) < $signed(b));
    assign any_bit = |(a & b);

    // Select the outcome for the decoded condition.
    always_comb begin
        unique case (cond)
            COND_ALWAYS: hit = 1'b1;
            COND_EQ:     hit = eq;
            COND_NE:     hit = !eq;
            COND_UGT:    hit = !ult && !eq;
            COND_UGE:    hit = !ult;
            COND_ULT:    hit = ult;
            COND_ULE:    hit = ult || eq;
            COND_SGT:    hit = !slt && !eq;
            COND_SGE:    hit = !slt;
            COND_SLT:    hit = slt;
            COND_SLE:    hit = slt || eq;
            COND_BITS:   hit = any_bit;
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/br_target.sv
// Target adder: next slot is pc + 1, plus the sign-extended offset when the
// jump is taken. Wraps modulo 2^PC_W. Assumes PC_W is wider than the offset.
module br_target
    import br_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic             take,
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    output logic [PC_W-1:0]  target
);

    localparam int EXT_W = PC_W - OFF_W;
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    logic [PC_W-1:0] off_ext;

    // Sign-extend the offset, or zero it when falling through.
    always_comb begin
        off_ext = take ? {{EXT_W{offset[OFF_W-1]}}, offset} : '0;
        target  = pc + ONE + off_ext;
    end

endmodule

// File: rtl/br_decide.sv
// Compare-and-branch decision unit, top level. Registers the decision one
// clock after in_valid. Assumes the caller holds no state for it; every
// presented instruction is judged independently.
module br_decide
    import br_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       opcode,
    input  logic [63:0]      dst_val,
    input  logic [63:0]      src_val,
    input  logic [31:0]      imm,
    input  logic [15:0]      offset,
    input  logic [PC_W-1:0]  pc,
    output logic             out_valid,
    output logic             taken,
    output logic             illegal,
    output logic [PC_W-1:0]  next_pc
);

    localparam int EXT_W = VAL_W - IMM_W;

    dec_t             dec;
    logic [VAL_W-1:0] comparand;
    logic             hit;
    logic             take;
    logic [PC_W-1:0]  target;

    br_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    // Comparand: source register or sign-extended immediate.
    always_comb begin
        comparand = dec.use_reg ? src_val : {{EXT_W{imm[IMM_W-1]}}, imm};
    end

    br_compare #(.W(VAL_W)) u_compare (
        .cond (dec.cond),
        .a    (dst_val),
        .b    (comparand),
        .hit  (hit)
    );

    assign take = dec.legal && hit;

    br_target #(.PC_W(PC_W)) u_target (
        .take   (take),
        .pc     (pc),
        .offset (offset),
        .target (target)
    );

    // Result register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            illegal   <= 1'b0;
            next_pc   <= '0;
        end else begin
            out_valid <= in_valid;
            taken     <= take;
            illegal   <= !dec.legal;
            next_pc   <= target;
        end
    end

endmodule

// File: rtl/br_decide_chk.sv
// Property checker for br_decide, attached by bind. Observes ports only.
module br_decide_chk #(
    parameter int PC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [7:0]       opcode,
    input logic [63:0]      dst_val,
    input logic [63:0]      src_val,
    input logic [15:0]      offset,
    input logic [PC_W-1:0]  pc,
    input logic             out_valid,
    input logic             taken,
    input logic             illegal,
    input logic [PC_W-1:0]  next_pc
);

    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_uncond_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h05) |=> taken);

    p_reg_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h1d && dst_val == src_val) |=> taken);

    p_illegal_not_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> !taken);

    p_fallthrough_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> next_pc == $past(pc) + ONE);

    p_taken_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && taken) |->
        next_pc == $past(pc) + ONE + {{(PC_W-16){$past(offset[15])}}, $past(offset)});

endmodule

bind br_decide br_decide_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .dst_val   (dst_val),
    .src_val   (src_val),
    .offset    (offset),
    .pc        (pc),
    .out_valid (out_valid),
    .taken     (taken),
    .illegal   (illegal),
    .next_pc   (next_pc)
);

// File: tb/tb_br_decide.sv
`timescale 1ns/1ps
module tb_br_decide;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [7:0]      opcode = '0;
    logic [63:0]     dst_val = '0;
    logic [63:0]     src_val = '0;
    logic [31:0]     imm = '0;
    logic [15:0]     offset = '0;
    logic [PC_W-1:0] pc = '0;
    logic            out_valid, taken, illegal;
    logic [PC_W-1:0] next_pc;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    br_decide #(.PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset),
        .pc(pc), .out_valid(out_valid), .taken(taken), .illegal(illegal),
        .next_pc(next_pc)
    );

    // Expected legality per R11.
    function automatic bit exp_legal(input logic [7:0] op);
        if (op[2:0] != 3'b101) return 1'b0;
        if (op == 8'h05) return 1'b1;
        case (op[7:4])
            4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7,
            4'hA, 4'hB, 4'hC, 4'hD: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Expected decision per R3-R8.
    function automatic bit exp_taken(input logic [7:0] op, input logic [63:0] d,
                                     input logic [63:0] s, input logic [31:0] i);
        logic [63:0] b;
        longint sd, sb;
        if (!exp_legal(op)) return 1'b0;
        if (op == 8'h05) return 1'b1;
        b  = op[3] ? s : 64'($signed(i));
        sd = d;
        sb = b;
        case (op[7:4])
            4'h1: return d == b;
            4'h5: return d != b;
            4'h2: return d > b;
            4'h3: return d >= b;
            4'hA: return d < b;
            4'hB: return d <= b;
            4'h6: return sd > sb;
            4'h7: return sd >= sb;
            4'hC: return sd < sb;
            4'hD: return sd <= sb;
            4'h4: return (d & b) != 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] op);
        string t;
        if (!exp_legal(op)) return "R11";
        if (op == 8'h05) return "R3";
        case (op[7:4])
            4'h1, 4'h5: t = "R4";
            4'h4:       t = "R7";
            4'h6, 4'h7, 4'hC, 4'hD: t = "R6";
            default:    t = "R5";
        endcase
        return op[3] ? t : {t, " R8"};
    endfunction

    task automatic check_bit(input string tag, input string what,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s op=%02h actual=%0b expected=%0b", tag, what, opcode, act, exp);
        end
    endtask

    task automatic run_one(input logic [7:0] op, input logic [63:0] d,
                           input logic [63:0] s, input logic [31:0] i,
                           input logic [15:0] o, input logic [PC_W-1:0] p);
        bit t, lg;
        logic [PC_W-1:0] npc;
        @(negedge clk);
        opcode = op; dst_val = d; src_val = s; imm = i; offset = o; pc = p;
        in_valid = 1'b1;
        t   = exp_taken(op, d, s, i);
        lg  = exp_legal(op);
        npc = p + 1 + (t ? PC_W'($signed(o)) : '0);
        @(negedge clk);
        check_bit("R2", "out_valid", out_valid, 1'b1);
        check_bit(tag_of(op), "taken", taken, t);
        check_bit("R11", "illegal", illegal, !lg);
        checks++;
        if (next_pc !== npc) begin
            failures++;
            $display("FAIL %s next_pc op=%02h actual=%08h expected=%08h",
                     t ? "R9" : "R10", op, next_pc, npc);
        end
    endtask

    initial begin
        logic [63:0] pd [8];
        logic [63:0] ps [8];
        logic [31:0] pi [8];
        logic [15:0] po [8];
        logic [31:0] pp [8];
        pd[0] = 64'd5;                 ps[0] = 64'd5;                 pi[0] = 32'd5;
        pd[1] = 64'd3;                 ps[1] = 64'd7;                 pi[1] = 32'd7;
        pd[2] = '1;                    ps[2] = 64'd1;                 pi[2] = 32'hFFFF_FFFF;
        pd[3] = 64'h8000_0000_0000_0000; ps[3] = 64'h7FFF_FFFF_FFFF_FFFF; pi[3] = 32'h8000_0000;
        pd[4] = 64'h00F0;              ps[4] = 64'h0F00;              pi[4] = 32'h0010;
        pd[5] = 64'd0;                 ps[5] = 64'd0;                 pi[5] = 32'd0;
        pd[6] = 64'h1_0000_0000;       ps[6] = 64'h0000_0000_FFFF_FFFF; pi[6] = 32'h0;
        pd[7] = 64'hFFFF_FFFF_0000_0000; ps[7] = 64'd1;               pi[7] = 32'h8000_0001;
        po[0] = 16'd5;     pp[0] = 32'd100;
        po[1] = 16'hFFFF;  pp[1] = 32'd0;
        po[2] = 16'd0;     pp[2] = 32'hFFFF_FFFF;
        po[3] = 16'hFFF8;  pp[3] = 32'd7;
        po[4] = 16'h7FFF;  pp[4] = 32'hFFFF_8000;
        po[5] = 16'h8000;  pp[5] = 32'd1000;
        po[6] = 16'd1;     pp[6] = 32'h7FFF_FFFE;
        po[7] = 16'hFFFE;  pp[7] = 32'd1;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R1", "out_valid", out_valid, 1'b0);
        check_bit("R1", "taken", taken, 1'b0);
        check_bit("R1", "illegal", illegal, 1'b0);
        checks++;
        if (next_pc !== '0) begin
            failures++;
            $display("FAIL R1 next_pc actual=%08h expected=00000000", next_pc);
        end
        rst_n = 1'b1;

        // Sweep every opcode against every operand and PC pattern.
        for (int op = 0; op < 256; op++) begin
            for (int k = 0; k < 8; k++) begin
                run_one(8'(op), pd[k], ps[k], pi[k], po[k], pp[k]);
            end
        end

        // R2: idle cycle gives no valid result
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R2", "out_valid idle", out_valid, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule